// File: doc/BRIEF.md
# Cascaded Timer Divisor Selector

This block picks a pair of 16-bit reload values for two counters chained in series, so that the oscillator period multiplied by both divisors comes as close as possible to a requested period. The caller presents the oscillator period, the requested period, a rounding mode and the pair currently in use, then pulses `start`. The block first checks whether the present pair already hits the request exactly. If it does, it returns the pair unchanged after two cycles. If it does not, it runs a sequential search over divisor pairs and returns the chosen pair and the period that pair achieves.

The search first works out the ideal overall divider, which is the request divided by the oscillator period. For each outer divisor it then walks a short run of inner divisors around the matching quotient. Along the way it keeps two records: the best achievable period at or below the request, and the best achievable period at or above it. When the search ends, the rounding mode decides which record is returned. All division is done by one shared restoring divider that produces one quotient bit per cycle.

Top module: `cascade_divisor_search`

## Requirements
- R1: Each returned divisor stands for a value from 2 to 65536. The value 65536 appears in its 16-bit output as 0, so an output of 1 never appears. An input divisor of 0 is also read as 65536.
- R2: The early exit applies when the incoming pair, with 0 read as 65536, gives a product times the oscillator period exactly equal to the request, both divisors are at least 2, and nothing overflows. In that case `done` is seen two cycles after the `start` cycle, the outputs equal the incoming pair, and the period output equals the request.
- R3: 32-bit overflow is detected. The early exit is refused if the divisor product or the period does not fit in 32 bits, and any search candidate whose period does not fit in 32 bits is skipped.
- R4: Search order. The ideal divider D is the request divided by the oscillator period, using integer division. The outer divisor a starts at the larger of 2 and D/65536 and rises by one. The search ends once a exceeds D/a+1 or exceeds 65536. For each a, the inner divisor b starts at D/a and rises while a*b is no more than D+a+1 and b is no more than 65536. Only pairs with b of at least 2 are scored. A record is replaced only by a strictly better period, so on a tie the earliest pair found is kept.
- R5: Rounding mode encoding: 0 and 3 select nearest, 1 selects down, 2 selects up. In nearest mode the upper record is taken only when its distance above the request is strictly smaller than the lower record's distance below it. On an exact tie the lower record is taken.
- R6: Down mode returns the lower record. If no lower record exists, it returns the upper record.
- R7: Up mode returns the upper record. If no upper record exists, it returns the lower record.
- R8: If the search finds no usable candidate at all, the result is the pair (2, 2).
- R9: The period output equals the oscillator period times both returned divisors, taken modulo 2^32.
- R10: Handshake. `start` is accepted whenever `busy` is low, and this includes the cycle in which `done` is high. `busy` is high from the cycle after acceptance until `done`. `done` stays high for exactly one cycle. A `start` that arrives while `busy` is high is ignored, and so is any change on the request inputs after acceptance. The outputs change only in the cycle where `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse; inputs are captured when it is accepted |
| osc_ns | input | 32 | Oscillator period in ns |
| req_ns | input | 32 | Requested period in ns |
| round_mode | input | 2 | 0/3 nearest, 1 down, 2 up |
| cur_div_a | input | 16 | Present first divisor (0 means 65536) |
| cur_div_b | input | 16 | Present second divisor (0 means 65536) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse; results are valid |
| div_a | output | 16 | Chosen first divisor (0 means 65536) |
| div_b | output | 16 | Chosen second divisor (0 means 65536) |
| period_ns | output | 32 | Achieved period |

## Verification
The completion pulse and the acceptance of a new request can fall in the same cycle. The bench provokes this by raising `start` with fresh inputs at the exact sampling point where `done` is first seen high. It then judges that `busy` is high one cycle later, and that the second result matches the reference search for the second inputs rather than repeating the first. As a counterpart, a `start` that carries different inputs in the middle of a search must leave the first result unchanged.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_BASE   = 3'd2,
        ST_OUTER  = 3'd3,
        ST_QUOT   = 3'd4,
        ST_INNER  = 3'd5,
        ST_FINISH = 3'd6,
        ST_DONE   = 3'd7
    } tdiv_state_e;

    localparam logic [1:0] RND_NEAR     = 2'd0;
    localparam logic [1:0] RND_DOWN     = 2'd1;
    localparam logic [1:0] RND_UP       = 2'd2;
    localparam logic [1:0] RND_NEAR_ALT = 2'd3;

endpackage

// File: rtl/tdiv_iterdiv.sv
// Restoring unsigned divider, one quotient bit per cycle.
module tdiv_iterdiv #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         valid,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          run;
        logic          vld;
        logic [CW-1:0] cnt;
        logic [W:0]    rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  den;
    } div_state_t;

    div_state_t dv_d, dv_q;
    logic [W:0]   rem_sh;
    logic [W-1:0] quo_sh;

    always_comb begin
        dv_d   = dv_q;
        dv_d.vld = 1'b0;
        rem_sh = {dv_q.rem[W-1:0], dv_q.quo[W-1]};
        quo_sh = {dv_q.quo[W-2:0], 1'b0};
        if (!dv_q.run) begin
            if (go) begin
                dv_d.run = 1'b1;
                dv_d.cnt = '0;
                dv_d.rem = '0;
                dv_d.quo = num;
                dv_d.den = den;
            end
        end else begin
            if (rem_sh >= {1'b0, dv_q.den}) begin
                rem_sh    = rem_sh - {1'b0, dv_q.den};
                quo_sh[0] = 1'b1;
            end
            dv_d.rem = rem_sh;
            dv_d.quo = quo_sh;
            if (dv_q.cnt == CW'(W - 1)) begin
                dv_d.run = 1'b0;
                dv_d.vld = 1'b1;
            end else begin
                dv_d.cnt = dv_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign valid = dv_q.vld;
    assign quo   = dv_q.quo;
endmodule

// File: rtl/tdiv_eval.sv
// Scores one divisor pair: period, fit against a product limit, usability.
module tdiv_eval #(
    parameter int DP_W  = 32,
    parameter int CNT_W = 16
) (
    input  logic [DP_W-1:0]       osc,
    input  logic [DP_W:0]         a,
    input  logic [DP_W:0]         b,
    input  logic [2*DP_W+1:0]     limit,
    output logic [DP_W-1:0]       ns,
    output logic                  fit,
    output logic                  usable
);
    localparam int IDX_W = DP_W + 1;
    localparam int PRD_W = 2 * IDX_W;
    localparam int NS_W  = PRD_W + DP_W;
    localparam logic [IDX_W-1:0] MAX_DIV = IDX_W'(1) << CNT_W;

    logic [PRD_W-1:0] prod;
    logic [NS_W-1:0]  ns_wide;
    logic             ovf;

    always_comb begin
        prod    = PRD_W'(a) * PRD_W'(b);
        ns_wide = NS_W'(prod) * NS_W'(osc);
        ovf     = |ns_wide[NS_W-1:DP_W];
        ns      = ns_wide[DP_W-1:0];
        fit     = prod <= limit;
        usable  = !ovf && (a >= IDX_W'(2)) && (b >= IDX_W'(2))
                  && (a <= MAX_DIV) && (b <= MAX_DIV);
    end
endmodule

// File: rtl/tdiv_pick.sv
// Final rounding choice between the lower and upper records.
module tdiv_pick #(
    parameter int DP_W = 32
) (
    input  logic [1:0]      mode,
    input  logic [DP_W-1:0] req,
    input  logic            glb_vld,
    input  logic [DP_W-1:0] glb_ns,
    input  logic            lub_vld,
    input  logic [DP_W-1:0] lub_ns,
    output logic            take_upper,
    output logic            none
);
    import tdiv_pkg::*;

    always_comb begin
        none = !glb_vld && !lub_vld;
        case (mode)
            RND_DOWN: take_upper = !glb_vld;
            RND_UP:   take_upper = lub_vld;
            default: begin
                if (glb_vld && lub_vld)
                    take_upper = (lub_ns - req) < (req - glb_ns);
                else
                    take_upper = lub_vld;
            end
        endcase
    end
endmodule

// File: rtl/cascade_divisor_search.sv
module cascade_divisor_search #(
    parameter int DP_W  = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DP_W-1:0]  osc_ns,
    input  logic [DP_W-1:0]  req_ns,
    input  logic [1:0]       round_mode,
    input  logic [CNT_W-1:0] cur_div_a,
    input  logic [CNT_W-1:0] cur_div_b,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] div_a,
    output logic [CNT_W-1:0] div_b,
    output logic [DP_W-1:0]  period_ns
);
    import tdiv_pkg::*;

    localparam int IDX_W = DP_W + 1;
    localparam int PRD_W = 2 * IDX_W;
    localparam logic [IDX_W-1:0] MAX_DIV = IDX_W'(1) << CNT_W;

    typedef struct packed {
        tdiv_state_e      st;
        logic [DP_W-1:0]  osc;
        logic [DP_W-1:0]  req;
        logic [1:0]       mode;
        logic [CNT_W-1:0] in1;
        logic [CNT_W-1:0] in2;
        logic [DP_W-1:0]  divider;
        logic [IDX_W-1:0] div1;
        logic [IDX_W-1:0] div2;
        logic             glb_vld;
        logic [DP_W-1:0]  glb_ns;
        logic [CNT_W-1:0] glb_d1;
        logic [CNT_W-1:0] glb_d2;
        logic             lub_vld;
        logic [DP_W-1:0]  lub_ns;
        logic [CNT_W-1:0] lub_d1;
        logic [CNT_W-1:0] lub_d2;
        logic [CNT_W-1:0] out1;
        logic [CNT_W-1:0] out2;
        logic [DP_W-1:0]  per;
    } srch_state_t;

    srch_state_t s_d, s_q;

    // shared divider
    logic            div_go;
    logic [DP_W-1:0] div_num, div_den;
    logic            div_valid;
    logic [DP_W-1:0] div_quo;

    tdiv_iterdiv #(.W(DP_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .valid (div_valid),
        .quo   (div_quo)
    );

    // early-exit scoring of the incoming pair
    logic [IDX_W-1:0] exit_a, exit_b;
    logic [DP_W-1:0]  exit_ns;
    logic             exit_fit, exit_use, exit_hit;

    assign exit_a = (s_q.in1 == '0) ? MAX_DIV : IDX_W'(s_q.in1);
    assign exit_b = (s_q.in2 == '0) ? MAX_DIV : IDX_W'(s_q.in2);

    tdiv_eval #(.DP_W(DP_W), .CNT_W(CNT_W)) u_exit (
        .osc    (s_q.osc),
        .a      (exit_a),
        .b      (exit_b),
        .limit  (PRD_W'({DP_W{1'b1}})),
        .ns     (exit_ns),
        .fit    (exit_fit),
        .usable (exit_use)
    );

    assign exit_hit = exit_use && exit_fit && (exit_ns == s_q.req);

    // scoring of the current search pair
    logic [PRD_W-1:0] try_limit;
    logic [DP_W-1:0]  try_ns;
    logic             try_fit, try_use, try_keep;

    assign try_limit = PRD_W'(s_q.divider) + PRD_W'(s_q.div1) + PRD_W'(1);

    tdiv_eval #(.DP_W(DP_W), .CNT_W(CNT_W)) u_try (
        .osc    (s_q.osc),
        .a      (s_q.div1),
        .b      (s_q.div2),
        .limit  (try_limit),
        .ns     (try_ns),
        .fit    (try_fit),
        .usable (try_use)
    );

    assign try_keep = try_fit && (s_q.div2 <= MAX_DIV);

    // rounding choice
    logic pick_upper, pick_none;

    tdiv_pick #(.DP_W(DP_W)) u_pick (
        .mode       (s_q.mode),
        .req        (s_q.req),
        .glb_vld    (s_q.glb_vld),
        .glb_ns     (s_q.glb_ns),
        .lub_vld    (s_q.lub_vld),
        .lub_ns     (s_q.lub_ns),
        .take_upper (pick_upper),
        .none       (pick_none)
    );

    logic [DP_W-1:0] base_start;

    always_comb begin
        s_d     = s_q;
        div_go  = 1'b0;
        div_num = s_q.req;
        div_den = s_q.osc;
        base_start = div_quo >> CNT_W;
        if (base_start < DP_W'(2)) base_start = DP_W'(2);

        case (s_q.st)
            ST_IDLE, ST_DONE: begin
                s_d.st = ST_IDLE;
                if (start) begin
                    s_d.osc  = osc_ns;
                    s_d.req  = req_ns;
                    s_d.mode = round_mode;
                    s_d.in1  = cur_div_a;
                    s_d.in2  = cur_div_b;
                    s_d.st   = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (exit_hit) begin
                    s_d.out1 = s_q.in1;
                    s_d.out2 = s_q.in2;
                    s_d.per  = s_q.req;
                    s_d.st   = ST_DONE;
                end else begin
                    div_go      = 1'b1;
                    div_num     = s_q.req;
                    div_den     = s_q.osc;
                    s_d.glb_vld = 1'b0;
                    s_d.lub_vld = 1'b0;
                    s_d.st      = ST_BASE;
                end
            end
            ST_BASE: begin
                if (div_valid) begin
                    s_d.divider = div_quo;
                    s_d.div1    = IDX_W'(base_start);
                    s_d.st      = ST_OUTER;
                end
            end
            ST_OUTER: begin
                if (s_q.div1 > MAX_DIV) begin
                    s_d.st = ST_FINISH;
                end else begin
                    div_go  = 1'b1;
                    div_num = s_q.divider;
                    div_den = s_q.div1[DP_W-1:0];
                    s_d.st  = ST_QUOT;
                end
            end
            ST_QUOT: begin
                if (div_valid) begin
                    if (s_q.div1 > ({1'b0, div_quo} + IDX_W'(1))) begin
                        s_d.st = ST_FINISH;
                    end else begin
                        s_d.div2 = {1'b0, div_quo};
                        s_d.st   = ST_INNER;
                    end
                end
            end
            ST_INNER: begin
                if (try_keep) begin
                    if (try_use && try_ns <= s_q.req
                        && (!s_q.glb_vld || try_ns > s_q.glb_ns)) begin
                        s_d.glb_vld = 1'b1;
                        s_d.glb_ns  = try_ns;
                        s_d.glb_d1  = s_q.div1[CNT_W-1:0];
                        s_d.glb_d2  = s_q.div2[CNT_W-1:0];
                    end
                    if (try_use && try_ns >= s_q.req
                        && (!s_q.lub_vld || try_ns < s_q.lub_ns)) begin
                        s_d.lub_vld = 1'b1;
                        s_d.lub_ns  = try_ns;
                        s_d.lub_d1  = s_q.div1[CNT_W-1:0];
                        s_d.lub_d2  = s_q.div2[CNT_W-1:0];
                    end
                    s_d.div2 = s_q.div2 + IDX_W'(1);
                end else begin
                    s_d.div1 = s_q.div1 + IDX_W'(1);
                    s_d.st   = ST_OUTER;
                end
            end
            ST_FINISH: begin
                if (pick_none) begin
                    s_d.out1 = CNT_W'(2);
                    s_d.out2 = CNT_W'(2);
                    s_d.per  = s_q.osc << 2;
                end else if (pick_upper) begin
                    s_d.out1 = s_q.lub_d1;
                    s_d.out2 = s_q.lub_d2;
                    s_d.per  = s_q.lub_ns;
                end else begin
                    s_d.out1 = s_q.glb_d1;
                    s_d.out2 = s_q.glb_d2;
                    s_d.per  = s_q.glb_ns;
                end
                s_d.st = ST_DONE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic [DP_W-1:0] osc_cap;
    assign osc_cap = s_q.osc;

    assign busy      = (s_q.st != ST_IDLE) && (s_q.st != ST_DONE);
    assign done      = (s_q.st == ST_DONE);
    assign div_a     = s_q.out1;
    assign div_b     = s_q.out2;
    assign period_ns = s_q.per;
endmodule

// File: rtl/tdiv_checker.sv
module tdiv_checker #(
    parameter int DP_W  = 32,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] div_a,
    input logic [CNT_W-1:0] div_b,
    input logic [DP_W-1:0]  period_ns,
    input logic [DP_W-1:0]  osc_cap
);
    localparam int DW   = CNT_W + 1;
    localparam int NS_W = 2 * DW + DP_W;

    logic [DW-1:0]   dec_a, dec_b;
    logic [NS_W-1:0] exp_ns;

    assign dec_a  = (div_a == '0) ? (DW'(1) << CNT_W) : DW'(div_a);
    assign dec_b  = (div_b == '0) ? (DW'(1) << CNT_W) : DW'(div_b);
    assign exp_ns = NS_W'(dec_a) * NS_W'(dec_b) * NS_W'(osc_cap);

    // R10: completion pulse lasts one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: an accepted start makes the block busy next cycle
    a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10: results move only when done rises
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(div_a) && $stable(div_b) && $stable(period_ns)));

    // R1: a divisor register never holds 1
    a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (div_a != CNT_W'(1) && div_b != CNT_W'(1)));

    // R9: period agrees with the returned pair
    a_r9_period: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (period_ns == exp_ns[DP_W-1:0]));
endmodule

bind cascade_divisor_search tdiv_checker #(.DP_W(DP_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .div_a     (div_a),
    .div_b     (div_b),
    .period_ns (period_ns),
    .osc_cap   (osc_cap)
);

// File: tb/tb_cascade_divisor_search.sv
module tb_cascade_divisor_search;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] osc_ns = '0, req_ns = '0;
    logic [1:0]  round_mode = '0;
    logic [15:0] cur_div_a = '0, cur_div_b = '0;
    logic        busy, done;
    logic [15:0] div_a, div_b;
    logic [31:0] period_ns;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    logic [15:0] g1, g2;
    logic [31:0] gp;

    always #2 clk = ~clk;

    cascade_divisor_search dut (
        .clk(clk), .rst_n(rst_n), .start(start), .osc_ns(osc_ns),
        .req_ns(req_ns), .round_mode(round_mode), .cur_div_a(cur_div_a),
        .cur_div_b(cur_div_b), .busy(busy), .done(done), .div_a(div_a),
        .div_b(div_b), .period_ns(period_ns)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference search written from the requirements.
    function automatic void ref_model(input longint unsigned osc, req,
                                      input int mode,
                                      input longint unsigned i1, i2,
                                      output longint unsigned o1, o2, per);
        longint unsigned mx = 65536, lim = 64'h1_0000_0000;
        longint unsigned e1, e2, p, dv, st, q;
        longint unsigned gns = 0, lns = 0, g1m = 0, g2m = 0, l1m = 0, l2m = 0;
        bit gv = 0, lv = 0, up;
        e1 = (i1 == 0) ? mx : i1;
        e2 = (i2 == 0) ? mx : i2;
        p  = e1 * e2;
        if (p < lim && p * osc < lim && p * osc == req && e1 > 1 && e2 > 1) begin
            o1 = i1; o2 = i2; per = req; return;
        end
        dv = req / osc;
        st = dv / 65536;
        if (st < 2) st = 2;
        for (longint unsigned a = st; a <= mx; a++) begin
            q = dv / a;
            if (a > q + 1) break;
            for (longint unsigned b = q; a * b <= dv + a + 1 && b <= mx; b++) begin
                longint unsigned pr, ns;
                if (b < 2) continue;
                pr = a * b;
                if (pr >= lim || pr * osc >= lim) continue;
                ns = pr * osc;
                if (ns <= req && (!gv || ns > gns)) begin gv = 1; gns = ns; g1m = a; g2m = b; end
                if (ns >= req && (!lv || ns < lns)) begin lv = 1; lns = ns; l1m = a; l2m = b; end
            end
        end
        if (mode == 1)      up = !gv;
        else if (mode == 2) up = lv;
        else if (gv && lv)  up = (lns - req) < (req - gns);
        else                up = lv;
        if (!gv && !lv) begin o1 = 2; o2 = 2; per = (osc * 4) % lim; end
        else if (up) begin o1 = l1m % mx; o2 = l2m % mx; per = lns; end
        else begin o1 = g1m % mx; o2 = g2m % mx; per = gns; end
    endfunction

    task automatic drive(input logic [31:0] o, r, input logic [1:0] m,
                         input logic [15:0] a, b);
        osc_ns = o; req_ns = r; round_mode = m; cur_div_a = a; cur_div_b = b;
        start = 1'b1;
    endtask

    task automatic wait_done(input string tag, output int lat);
        lat = 1;
        while (!done && lat < 60000) begin @(negedge clk); lat++; end
        if (!done) chk({tag, " R10 timeout"}, 0, 1);
        g1 = div_a; g2 = div_b; gp = period_ns;
        @(negedge clk);
        chk({tag, " R10 done one cycle"}, done, 0);
    endtask

    task automatic run_job(input string tag, input logic [31:0] o, r,
                           input logic [1:0] m, input logic [15:0] a, b,
                           output int lat);
        @(negedge clk);
        drive(o, r, m, a, b);
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R10 busy after start"}, busy, 1);
        wait_done(tag, lat);
    endtask

    task automatic expect_job(input string tag, input logic [31:0] o, r,
                              input logic [1:0] m, input logic [15:0] a, b);
        longint unsigned e1, e2, ep;
        int lat;
        run_job(tag, o, r, m, a, b, lat);
        ref_model(o, r, m, a, b, e1, e2, ep);
        chk({tag, " div_a"}, g1, e1);
        chk({tag, " div_b"}, g2, e2);
        chk({tag, " period"}, gp, ep);
    endtask

    task automatic t_reset;
        chk("R10 reset busy", busy, 0);
        chk("R10 reset done", done, 0);
        chk("R9 reset period", period_ns, 0);
        chk("R1 reset div_a", div_a, 0);
    endtask

    task automatic t_early_exit;
        int lat;
        run_job("R2 exact", 100, 20000, 0, 10, 20, lat);
        chk("R2 exact div_a", g1, 10);
        chk("R2 exact div_b", g2, 20);
        chk("R2 exact period", gp, 20000);
        chk("R2 exact latency", lat, 2);
        run_job("R1 R2 max", 1, 131072, 0, 0, 2, lat);
        chk("R1 R2 zero kept div_a", g1, 0);
        chk("R1 R2 zero kept div_b", g2, 2);
    endtask

    task automatic t_exit_refused;
        expect_job("R3 exit overflow", 1, 0, 0, 0, 0);
        chk("R3 R8 overflow no exit", gp, 4);
        expect_job("R1 R2 divisor one", 10, 1000, 0, 1, 100);
        chk("R1 never one", (g1 == 1 || g2 == 1), 0);
    endtask

    task automatic t_modes;
        expect_job("R4 R5 nearest", 10, 10093, 0, 3, 3);
        expect_job("R6 down", 10, 10093, 1, 3, 3);
        chk("R6 down below", gp <= 10093, 1);
        expect_job("R7 up", 10, 10093, 2, 3, 3);
        chk("R7 up above", gp >= 10093, 1);
        expect_job("R5 mode3", 10, 10093, 3, 3, 3);
    endtask

    task automatic t_tie;
        int lat;
        run_job("R5 tie", 1, 1009, 0, 3, 3, lat);
        chk("R5 tie div_a", g1, 2);
        chk("R5 tie div_b", g2, 504);
        chk("R5 tie lower", gp, 1008);
    endtask

    task automatic t_small;
        int lat;
        run_job("R6 fallback", 100, 250, 1, 3, 3, lat);
        chk("R6 fallback div_a", g1, 2);
        chk("R6 fallback period", gp, 400);
        run_job("R8 none", 100, 50, 2, 3, 3, lat);
        chk("R8 none div_a", g1, 2);
        chk("R8 none div_b", g2, 2);
        chk("R8 R9 none period", gp, 400);
    endtask

    task automatic t_large;
        int lat;
        run_job("R1 large", 1, 131072, 1, 5, 5, lat);
        chk("R1 large div_a", g1, 2);
        chk("R1 large encoded 65536", g2, 0);
        chk("R9 large period", gp, 131072);
    endtask

    task automatic t_up_fallback;
        int lat;
        run_job("R7 R3 up none", 32'h1000_0000, 32'hF800_0000, 2, 3, 3, lat);
        chk("R7 R3 div_a", g1, 3);
        chk("R7 R3 div_b", g2, 5);
        chk("R7 R3 period", gp, 32'hF000_0000);
    endtask

    task automatic t_ignore_busy;
        longint unsigned e1, e2, ep;
        int lat;
        @(negedge clk);
        drive(7, 50000, 2, 3, 3);
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        drive(13, 777, 1, 9, 9);
        @(negedge clk);
        start = 1'b0;
        wait_done("R10 ignore", lat);
        ref_model(7, 50000, 2, 3, 3, e1, e2, ep);
        chk("R10 ignore div_a", g1, e1);
        chk("R10 ignore div_b", g2, e2);
        chk("R10 ignore period", gp, ep);
    endtask

    task automatic t_back_to_back;
        longint unsigned e1, e2, ep;
        int lat;
        @(negedge clk);
        drive(10, 10093, 0, 3, 3);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 60000) begin @(negedge clk); lat++; end
        drive(3, 4000, 2, 3, 3);
        @(negedge clk);
        start = 1'b0;
        chk("R10 restart in done cycle", busy, 1);
        wait_done("R10 b2b", lat);
        ref_model(3, 4000, 2, 3, 3, e1, e2, ep);
        chk("R10 b2b div_a", g1, e1);
        chk("R10 b2b div_b", g2, e2);
        chk("R10 b2b period", gp, ep);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                tests++; fails++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_early_exit;
        t_exit_refused;
        t_modes;
        t_tie;
        t_small;
        t_large;
        t_up_fallback;
        t_ignore_busy;
        t_back_to_back;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule